// File: doc/BRIEF.md
# SD host transmit data-path controller

This block drives the transmit half of an SD/SDIO host data path on one DAT line. Software or a bus bridge writes 32-bit words into a 32-entry transmit FIFO. A one-cycle `start` pulse launches a transfer of `xfer_words` words. The controller sends one bit per clock, most significant bit first. Each frame opens with a low start bit and closes with a high end bit.

In block mode the data is cut into blocks of `blk_words` words. Each block carries a CRC16 computed over its data bits only. The polynomial is x^16+x^12+x^5+1, the seed is all zeros, and the CRC is sent MSB first. After each block the controller listens on `dat_in` for the card's status token. The token is a low start bit, then three status bits, first received is the MSB, then an end bit. A status of `010` is positive and any other value is a failure. After a positive token, `dat_in` held low means the card is busy. The next block, or the end of the transfer, waits until the card releases the line. A timeout counter covers this whole post-block phase. In stream mode all words go out as one frame with no CRC and no token.

Every entry into the pre-send wait state holds the line idle for at least two clocks. Four sticky outcome flags report the result: done, CRC failure, timeout and FIFO underflow. They are cleared by the next accepted `start`. Lengths are counted in 32-bit words. `blk_words` must be at least 1. `stream_mode`, `blk_words` and `tmo_val` must stay stable while a transfer runs. `dat_in` must already be synchronous to `clk`.

Top module: `sd_tx_datapath`

## Requirements
- R1: After reset `dat_oe` is 0, `dat_out` is 1, all four outcome flags are 0 and `fifo_full` is 0.
- R2: The FIFO holds 32 words of 32 bits and raises `fifo_full` after 32 writes without reads. A write while full is dropped, and words leave in the order they were written.
- R3: `start` is accepted only when idle. It clears all outcome flags and loads the word count. A count of zero ends with `xfer_done`=1 without ever driving the line. At most one outcome flag is set at a time.
- R4: Before every start bit the controller spends at least two cycles in the pre-send wait state. `dat_oe` is low for at least two clocks after the card releases busy.
- R5: Each frame begins with one low start bit, followed by data bits MSB first, word by word in FIFO order.
- R6: In block mode, after `blk_words` words (or the last word of the transfer), the 16 CRC bits go out MSB first, followed by a high end bit.
- R7: In stream mode all `xfer_words` words form one frame with no CRC. The end bit follows the last data bit, and `xfer_done` rises without waiting for a token.
- R8: After a block, a token whose three status bits differ from `010` sets `err_crc` and returns to idle.
- R9: After a positive token, the controller waits while `dat_in` is low. Once it is high, it sends the next block, or sets `xfer_done` after the last one.
- R10: A counter starts at zero on the first post-block cycle and counts each cycle spent there. When it equals `tmo_val` before the card releases busy, `err_tmo` is set and the controller goes idle.
- R11: If the FIFO is empty when the next word of a frame is needed, `err_unf` is set, the line is released (`dat_oe`=0) and the controller goes idle.
- R12: `dat_oe` is high only from the start bit to the end bit of a frame, and `dat_out` is 1 whenever the line is not driven.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, one DAT bit per cycle |
| rst_n | input | 1 | Synchronous active-low reset |
| wr_en | input | 1 | FIFO write strobe |
| wr_data | input | 32 | FIFO write word |
| fifo_full | output | 1 | FIFO holds 32 words |
| start | input | 1 | Begin a transfer (accepted when idle) |
| stream_mode | input | 1 | 1 = stream frame, 0 = block mode |
| xfer_words | input | 16 | Total words to send |
| blk_words | input | 12 | Words per block (block mode) |
| tmo_val | input | 24 | Post-block timeout in cycles |
| dat_in | input | 1 | DAT0 as seen from the card (token and busy) |
| dat_out | output | 1 | Serial data driven to DAT0 |
| dat_oe | output | 1 | Host drives DAT0 |
| xfer_done | output | 1 | Transfer finished cleanly |
| err_crc | output | 1 | Negative CRC status token |
| err_tmo | output | 1 | Card busy or token exceeded timeout |
| err_unf | output | 1 | FIFO ran empty inside a frame |

## Verification
The assertions rely on three properties of the inputs:
- `start` pulses only while the outcome is settled.
- The card never drives a token while the host owns the line.
- `blk_words` is nonzero and the configuration does not change while a transfer runs.

The stimulus respects them. The configuration is set before each `start`. The card model answers only after it has seen the end bit. Every FIFO is filled before launch, except in the deliberate underflow case. Random rounds draw block sizes from 1 to 4, block counts from 1 to 3, stream lengths from 1 to 8 and busy lengths from 0 to 20, all under a generous timeout. Directed cases cover zero length, a full FIFO with a dropped extra write, a negative token, a forced timeout and underflow.

// File: rtl/sdtx_pkg.sv
// Shared types and constants of the SD transmit data path.
// Assumes: one DAT bit per clock, CRC16 x^16+x^12+x^5+1.
package sdtx_pkg;
    typedef enum logic [3:0] {
        ST_IDLE,
        ST_WAIT_S,
        ST_TX_START,
        ST_TX_DATA,
        ST_TX_CRC,
        ST_TX_END,
        ST_BSY_TW,
        ST_BSY_TOK,
        ST_BSY_TEND,
        ST_BSY_D0
    } tx_state_e;

    localparam int unsigned  CRC_W    = 16;
    localparam logic [15:0]  CRC_POLY = 16'h1021;
    localparam logic [2:0]   TOK_OK   = 3'b010;
endpackage

// File: rtl/sdtx_fifo.sv
// Show-ahead transmit FIFO: rd_data is the head word while not empty.
// Assumes: writes while full are dropped; reads while empty never occur.
module sdtx_fifo #(
    parameter int unsigned DW    = 32,
    parameter int unsigned DEPTH = 32
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          wr_en,
    input  logic [DW-1:0] wr_data,
    input  logic          rd_en,
    output logic [DW-1:0] rd_data,
    output logic          empty,
    output logic          full
);
    localparam int unsigned AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam int unsigned CW = AW + 1;

    logic [DW-1:0] mem [DEPTH];
    logic [AW-1:0] wr_ptr, rd_ptr;
    logic [CW-1:0] count;
    logic          do_wr, do_rd;

    assign full    = (count == CW'(DEPTH));
    assign empty   = (count == '0);
    assign do_wr   = wr_en && !full;
    assign do_rd   = rd_en && !empty;
    assign rd_data = mem[rd_ptr];

    function automatic logic [AW-1:0] ptr_inc(input logic [AW-1:0] p);
        return (p == AW'(DEPTH - 1)) ? '0 : p + 1'b1;
    endfunction

    // Store an accepted write word.
    always_ff @(posedge clk) begin
        if (do_wr) mem[wr_ptr] <= wr_data;
    end

    // Advance pointers and occupancy.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wr_ptr <= '0;
            rd_ptr <= '0;
            count  <= '0;
        end else begin
            if (do_wr) wr_ptr <= ptr_inc(wr_ptr);
            if (do_rd) rd_ptr <= ptr_inc(rd_ptr);
            case ({do_wr, do_rd})
                2'b10:   count <= count + 1'b1;
                2'b01:   count <= count - 1'b1;
                default: count <= count;
            endcase
        end
    end

    AST_NO_UNDERRUN: assert property (@(posedge clk) disable iff (!rst_n)
        rd_en |-> !empty);                                           // R11
    AST_FULL_DROPS_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
        (full && wr_en && !rd_en) |=> full);                         // R2
endmodule

// File: rtl/sdtx_crc16.sv
// Serial CRC16 generator with shift-out mode.
// upd folds din into the remainder, shift moves it left for transmission.
// Assumes: clr, upd and shift are never asserted together.
module sdtx_crc16 #(
    parameter int unsigned  W    = 16,
    parameter logic [W-1:0] POLY = 16'h1021
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         clr,
    input  logic         upd,
    input  logic         shift,
    input  logic         din,
    output logic [W-1:0] crc
);
    logic fb;
    assign fb = din ^ crc[W-1];

    // Update, shift out or clear the remainder.
    always_ff @(posedge clk) begin
        if (!rst_n || clr)  crc <= '0;
        else if (upd)       crc <= {crc[W-2:0], 1'b0} ^ (fb ? POLY : '0);
        else if (shift)     crc <= {crc[W-2:0], 1'b0};
    end
endmodule

// File: rtl/sd_tx_datapath.sv
// SD host transmit data path on a single DAT line.
// Sequence: pre-send wait (at least 2 cycles), frame out (start, data,
// CRC16 in block mode, end), then in block mode the card status token
// and DAT0 busy phase under a timeout, repeating per block.
// Assumes: dat_in synchronous; configuration stable during a transfer;
// blk_words >= 1.
module sd_tx_datapath #(
    parameter int unsigned DW     = 32,
    parameter int unsigned DEPTH  = 32,
    parameter int unsigned LEN_W  = 16,
    parameter int unsigned BLK_W  = 12,
    parameter int unsigned TMO_W  = 24
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_en,
    input  logic [DW-1:0]    wr_data,
    output logic             fifo_full,
    input  logic             start,
    input  logic             stream_mode,
    input  logic [LEN_W-1:0] xfer_words,
    input  logic [BLK_W-1:0] blk_words,
    input  logic [TMO_W-1:0] tmo_val,
    input  logic             dat_in,
    output logic             dat_out,
    output logic             dat_oe,
    output logic             xfer_done,
    output logic             err_crc,
    output logic             err_tmo,
    output logic             err_unf
);
    import sdtx_pkg::*;

    localparam int unsigned BIT_W = $clog2(DW);

    tx_state_e        state;
    logic [LEN_W-1:0] words_left;
    logic [BLK_W-1:0] blk_left;
    logic [DW-1:0]    shreg;
    logic [BIT_W-1:0] bit_cnt;
    logic             gap_done;
    logic [2:0]       tok_sr;
    logic [1:0]       tok_cnt;
    logic [TMO_W-1:0] tmo_cnt;

    logic [DW-1:0]    fifo_q;
    logic             fifo_empty, fifo_rd;
    logic [CRC_W-1:0] crc;
    logic             last_bit, xfer_end, blk_end, pop_first, pop_next, busy_st;

    assign last_bit  = (state == ST_TX_DATA) && (bit_cnt == BIT_W'(DW - 1));
    assign xfer_end  = (words_left == LEN_W'(1));
    assign blk_end   = !stream_mode && (blk_left == BLK_W'(1));
    assign pop_first = (state == ST_WAIT_S) && gap_done && (words_left != '0) && !fifo_empty;
    assign pop_next  = last_bit && !xfer_end && !blk_end && !fifo_empty;
    assign fifo_rd   = pop_first || pop_next;
    assign busy_st   = state inside {ST_BSY_TW, ST_BSY_TOK, ST_BSY_TEND, ST_BSY_D0};

    sdtx_fifo #(.DW(DW), .DEPTH(DEPTH)) u_fifo (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_data(wr_data),
        .rd_en(fifo_rd), .rd_data(fifo_q), .empty(fifo_empty), .full(fifo_full)
    );

    sdtx_crc16 #(.W(CRC_W), .POLY(CRC_POLY)) u_crc (
        .clk(clk), .rst_n(rst_n),
        .clr(state == ST_WAIT_S), .upd(state == ST_TX_DATA),
        .shift(state == ST_TX_CRC), .din(shreg[DW-1]), .crc(crc)
    );

    // Line drive decoded from the frame state.
    always_comb begin
        dat_oe  = state inside {ST_TX_START, ST_TX_DATA, ST_TX_CRC, ST_TX_END};
        case (state)
            ST_TX_START: dat_out = 1'b0;
            ST_TX_DATA:  dat_out = shreg[DW-1];
            ST_TX_CRC:   dat_out = crc[CRC_W-1];
            default:     dat_out = 1'b1;
        endcase
    end

    // Main sequencer: counters, shift register, token capture and flags.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state      <= ST_IDLE;
            words_left <= '0;
            blk_left   <= '0;
            shreg      <= '0;
            bit_cnt    <= '0;
            gap_done   <= 1'b0;
            tok_sr     <= '0;
            tok_cnt    <= '0;
            tmo_cnt    <= '0;
            xfer_done  <= 1'b0;
            err_crc    <= 1'b0;
            err_tmo    <= 1'b0;
            err_unf    <= 1'b0;
        end else begin
            gap_done <= (state == ST_WAIT_S);
            if (busy_st) tmo_cnt <= tmo_cnt + 1'b1;
            case (state)
                ST_IDLE: if (start) begin
                    words_left <= xfer_words;
                    xfer_done  <= 1'b0;
                    err_crc    <= 1'b0;
                    err_tmo    <= 1'b0;
                    err_unf    <= 1'b0;
                    state      <= ST_WAIT_S;
                end
                ST_WAIT_S: if (gap_done) begin
                    if (words_left == '0) begin
                        xfer_done <= 1'b1;
                        state     <= ST_IDLE;
                    end else if (!fifo_empty) begin
                        shreg    <= fifo_q;
                        blk_left <= blk_words;
                        state    <= ST_TX_START;
                    end
                end
                ST_TX_START: begin
                    bit_cnt <= '0;
                    state   <= ST_TX_DATA;
                end
                ST_TX_DATA: begin
                    shreg   <= {shreg[DW-2:0], 1'b0};
                    bit_cnt <= bit_cnt + 1'b1;
                    if (last_bit) begin
                        words_left <= words_left - 1'b1;
                        blk_left   <= blk_left - 1'b1;
                        bit_cnt    <= '0;
                        if (xfer_end || blk_end)
                            state <= stream_mode ? ST_TX_END : ST_TX_CRC;
                        else if (fifo_empty) begin
                            err_unf <= 1'b1;
                            state   <= ST_IDLE;
                        end else
                            shreg <= fifo_q;
                    end
                end
                ST_TX_CRC: begin
                    bit_cnt <= bit_cnt + 1'b1;
                    if (bit_cnt == BIT_W'(CRC_W - 1)) state <= ST_TX_END;
                end
                ST_TX_END: begin
                    tmo_cnt <= '0;
                    if (stream_mode) begin
                        xfer_done <= 1'b1;
                        state     <= ST_IDLE;
                    end else
                        state <= ST_BSY_TW;
                end
                default: begin
                    if (tmo_cnt == tmo_val) begin
                        err_tmo <= 1'b1;
                        state   <= ST_IDLE;
                    end else begin
                        case (state)
                            ST_BSY_TW: if (!dat_in) begin
                                tok_cnt <= '0;
                                state   <= ST_BSY_TOK;
                            end
                            ST_BSY_TOK: begin
                                tok_sr  <= {tok_sr[1:0], dat_in};
                                tok_cnt <= tok_cnt + 1'b1;
                                if (tok_cnt == 2'd2) state <= ST_BSY_TEND;
                            end
                            ST_BSY_TEND: begin
                                if (tok_sr != TOK_OK) begin
                                    err_crc <= 1'b1;
                                    state   <= ST_IDLE;
                                end else
                                    state <= ST_BSY_D0;
                            end
                            default: if (dat_in) state <= ST_WAIT_S;
                        endcase
                    end
                end
            endcase
        end
    end

    AST_GAP_BEFORE_START: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(dat_oe) |-> ($past(state == ST_WAIT_S) && $past(state == ST_WAIT_S, 2))); // R4
    AST_START_BIT_LOW: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(dat_oe) |-> !dat_out);                                 // R5
    AST_END_BIT_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
        ($fell(dat_oe) && !err_unf) |-> $past(dat_out));             // R6
    AST_ONE_OUTCOME: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({xfer_done, err_crc, err_tmo, err_unf}));           // R3
    AST_TMO_FROM_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(err_tmo) |-> $past(busy_st));                          // R10
    AST_UNF_RELEASES: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(err_unf) |-> ($past(state == ST_TX_DATA) && !dat_oe)); // R11
    AST_CRC_FAIL_AFTER_TOKEN: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(err_crc) |-> $past(state == ST_BSY_TEND));             // R8
    AST_IDLE_LINE_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
        !dat_oe |-> dat_out);                                        // R12
endmodule

// File: tb/sim_sd_tx_datapath.sv
module sim_sd_tx_datapath;
    logic        clk = 1'b0;
    logic        rst_n;
    logic        wr_en;
    logic [31:0] wr_data;
    logic        fifo_full;
    logic        start;
    logic        stream_mode;
    logic [15:0] xfer_words;
    logic [11:0] blk_words;
    logic [23:0] tmo_val;
    logic        dat_in;
    logic        dat_out, dat_oe;
    logic        xfer_done, err_crc, err_tmo, err_unf;

    int          n_chk = 0;
    int          n_fail = 0;
    int          oe_cnt = 0;
    logic [31:0] exp_w [0:31];

    always #4 clk = ~clk;

    sd_tx_datapath u0 (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_data(wr_data),
        .fifo_full(fifo_full), .start(start), .stream_mode(stream_mode),
        .xfer_words(xfer_words), .blk_words(blk_words), .tmo_val(tmo_val),
        .dat_in(dat_in), .dat_out(dat_out), .dat_oe(dat_oe),
        .xfer_done(xfer_done), .err_crc(err_crc), .err_tmo(err_tmo), .err_unf(err_unf)
    );

    always @(negedge clk) if (dat_oe === 1'b1) oe_cnt++;

    task automatic chk(input bit ok, input string req, input string what,
                       input longint act, input longint exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    function automatic logic [15:0] calc_crc(input int first, input int n);
        logic [15:0] c = '0;
        for (int i = 0; i < n * 32; i++) begin
            logic b = exp_w[first + i / 32][31 - (i % 32)];
            logic fb = b ^ c[15];
            c = {c[14:0], 1'b0} ^ (fb ? 16'h1021 : 16'h0000);
        end
        return c;
    endfunction

    task automatic push_words(input int n);
        for (int i = 0; i < n; i++) begin
            logic [31:0] w = $urandom;
            exp_w[i] = w;
            @(negedge clk); wr_en = 1'b1; wr_data = w;
        end
        @(negedge clk); wr_en = 1'b0;
    endtask

    task automatic pulse_start();
        @(negedge clk); start = 1'b1;
        @(negedge clk); start = 1'b0;
    endtask

    task automatic card_frame(input int nw, input bit blk, input bit first, input int w0);
        int idle = 0;
        int mism = 0;
        int cmis = 0;
        logic [15:0] c;
        bit found = 0;
        while (!found && idle < 600) begin
            @(negedge clk);
            if (dat_oe && !dat_out) found = 1; else idle++;
        end
        chk(found, "R5", "start bit seen", found, 1);
        if (!found) return;
        chk(idle >= (first ? 1 : 2), "R4", "idle gap before start", idle, first ? 1 : 2);
        for (int i = 0; i < nw * 32; i++) begin
            @(negedge clk);
            if (!dat_oe || dat_out !== exp_w[w0 + i / 32][31 - (i % 32)]) mism++;
        end
        chk(mism == 0, "R5", "data bit mismatches", mism, 0);
        if (blk) begin
            c = calc_crc(w0, nw);
            for (int k = 0; k < 16; k++) begin
                @(negedge clk);
                if (!dat_oe || dat_out !== c[15 - k]) cmis++;
            end
            chk(cmis == 0, "R6", "crc bit mismatches", cmis, 0);
        end
        @(negedge clk);
        chk(dat_oe && dat_out, blk ? "R6" : "R7", "end bit", {dat_oe, dat_out}, 3);
    endtask

    task automatic card_token(input logic [2:0] st, input int busy);
        @(negedge clk); dat_in = 1'b1;
        @(negedge clk); dat_in = 1'b0;
        for (int k = 0; k < 3; k++) begin
            @(negedge clk); dat_in = st[2 - k];
        end
        @(negedge clk); dat_in = 1'b1;
        for (int k = 0; k < busy; k++) begin
            @(negedge clk); dat_in = 1'b0;
        end
        @(negedge clk); dat_in = 1'b1;
    endtask

    task automatic wait_outcome();
        int g = 0;
        while (!(xfer_done || err_crc || err_tmo || err_unf) && g < 600) begin
            @(negedge clk); g++;
        end
    endtask

    task automatic run_block(input int nw, input int bw, input logic [2:0] tok,
                             input int busy, input int tmo);
        int nb = (nw + bw - 1) / bw;
        stream_mode = 1'b0; xfer_words = 16'(nw); blk_words = 12'(bw); tmo_val = 24'(tmo);
        pulse_start();
        for (int b = 0; b < nb; b++) begin
            int n = (nw - b * bw < bw) ? nw - b * bw : bw;
            card_frame(n, 1'b1, b == 0, b * bw);
            card_token(tok, busy);
        end
        wait_outcome();
    endtask

    task automatic run_stream(input int nw);
        stream_mode = 1'b1; xfer_words = 16'(nw); blk_words = 12'd1; tmo_val = 24'd1000;
        pulse_start();
        card_frame(nw, 1'b0, 1'b1, 0);
        wait_outcome();
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        n_chk++; n_fail++;
        $display("FAIL watchdog expired");
        $display("  TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
        $finish;
    end

    initial begin
        int seed_ret;
        seed_ret = $urandom(32'h5EED);
        rst_n = 1'b0; wr_en = 1'b0; wr_data = '0; start = 1'b0; stream_mode = 1'b0;
        xfer_words = '0; blk_words = 12'd1; tmo_val = 24'd1000; dat_in = 1'b1;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1: reset state
        chk(!dat_oe && dat_out, "R1", "line idle after reset", {dat_oe, dat_out}, 1);
        chk({xfer_done, err_crc, err_tmo, err_unf} == 4'b0, "R1", "flags after reset",
            {xfer_done, err_crc, err_tmo, err_unf}, 0);
        chk(!fifo_full, "R1", "fifo_full after reset", fifo_full, 0);

        // R3: zero-length transfer finishes without driving
        oe_cnt = 0;
        stream_mode = 1'b0; xfer_words = '0; pulse_start(); wait_outcome();
        chk(xfer_done, "R3", "zero length done", xfer_done, 1);
        chk(oe_cnt == 0, "R3", "zero length drove line", oe_cnt, 0);

        // R9: two blocks of two words, positive tokens, short busy
        push_words(4);
        run_block(4, 2, 3'b010, 3, 2000);
        chk(xfer_done && !err_crc && !err_tmo && !err_unf, "R9", "block transfer done",
            {xfer_done, err_crc, err_tmo, err_unf}, 8);

        // R7: stream of three words
        push_words(3);
        run_stream(3);
        chk(xfer_done, "R7", "stream done", {xfer_done, err_crc, err_tmo, err_unf}, 8);

        // R8: negative CRC status token
        push_words(2);
        run_block(2, 2, 3'b101, 0, 2000);
        chk(err_crc && !xfer_done, "R8", "crc fail flag", {xfer_done, err_crc, err_tmo, err_unf}, 4);
        chk(!dat_oe && dat_out, "R12", "line released after crc fail", {dat_oe, dat_out}, 1);

        // R10: card busy longer than the timeout
        push_words(1);
        run_block(1, 1, 3'b010, 200, 30);
        chk(err_tmo && !xfer_done, "R10", "timeout flag", {xfer_done, err_crc, err_tmo, err_unf}, 2);

        // R11: FIFO runs dry inside a frame
        push_words(2);
        stream_mode = 1'b0; xfer_words = 16'd4; blk_words = 12'd4; tmo_val = 24'd1000;
        pulse_start(); wait_outcome();
        chk(err_unf && !xfer_done, "R11", "underflow flag", {xfer_done, err_crc, err_tmo, err_unf}, 1);
        chk(!dat_oe, "R11", "line released on underflow", dat_oe, 0);

        // R2: fill to 32, extra write dropped, order preserved
        push_words(32);
        chk(fifo_full, "R2", "full after 32 writes", fifo_full, 1);
        @(negedge clk); wr_en = 1'b1; wr_data = 32'hDEAD_BEEF;
        @(negedge clk); wr_en = 1'b0;
        run_stream(32);
        chk(xfer_done && !fifo_full, "R2", "32-word stream done", {xfer_done, fifo_full}, 2);
        push_words(1);
        run_block(1, 1, 3'b010, 0, 2000);
        chk(xfer_done, "R2", "dropped word absent", {xfer_done, err_crc, err_tmo, err_unf}, 8);

        // Random rounds: R5 R6 R7 R9
        for (int r = 0; r < 8; r++) begin
            if ($urandom_range(0, 2) == 0) begin
                int nw = $urandom_range(1, 8);
                push_words(nw);
                run_stream(nw);
                chk(xfer_done, "R7", "random stream done", {xfer_done, err_crc, err_tmo, err_unf}, 8);
            end else begin
                int bw = $urandom_range(1, 4);
                int nw = bw * $urandom_range(1, 3) - $urandom_range(0, bw - 1);
                push_words(nw);
                run_block(nw, bw, 3'b010, $urandom_range(0, 20), 1000);
                chk(xfer_done, "R9", "random block done", {xfer_done, err_crc, err_tmo, err_unf}, 8);
            end
        end

        $display("  TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
        $finish;
    end
endmodule